// File: doc/BRIEF.md
# Font RAM Write Stream Decoder

This block sits behind a serial bus slave front end. The front end has already framed each transaction with a start strobe and a stop strobe. The decoder reads the bytes of the transaction one at a time. It turns them into single-cycle write commands for a small character font RAM. The font RAM holds eight user-defined characters. Each character has sixteen pixel lines, and each line is five pixels wide.

The decoder reads the two top bits of each byte to decide what the byte is: a character (segment) address, a line address, or pixel data. Three ways of sending data are supported:
- **Fully addressed:** a segment byte and a line byte come before every data byte.
- **Line only:** the segment is kept, and only a line byte comes before each data byte.
- **Streaming:** the segment and line are sent once, and every later byte is data. After each write the address moves forward on its own.

Once a transaction enters streaming, it stays there until the transaction ends. Any byte that does not fit the expected sequence raises a one-cycle error pulse and causes no write. The same happens for any attempt to address a character code outside the eight writable ones.

Top module: `font_stream_dec`

## Requirements
- R1: A byte with bits 7:6 = 2'b11 is a segment address. Its value is bits 3:0, and bits 5:4 have no effect. A value of 0 to 7 is accepted, and the decoder then expects a line byte. A value of 8 to 15 is a fixed-glyph code: it gives an error pulse, and the decoder goes on waiting for a segment.
- R2: A byte with bits 7:6 = 2'b00, received while a line is expected, sets the line to bits 3:0. The next byte is then always treated as pixel data, whatever its top bits are.
- R3: A byte with bits 7:6 = 2'b01 sets the line to bits 3:0 and enters streaming. It is accepted only as the byte that directly follows an accepted segment byte. In any other per-byte position it is an error.
- R4: A data byte causes one write. The data is bits 4:0 of the byte, and bits 7:5 are ignored. The 7-bit write address has the segment in bits 6:4 and the line in bits 3:0.
- R5: After a data byte in the per-byte formats, a segment byte (tag 11) is accepted. It starts a new segment/line/data group.
- R6: After a data byte in the per-byte formats, a tag 00 line byte is accepted. It keeps the current segment.
- R7: While streaming, every byte is data, whatever its tag. Streaming stays active until a stop or start strobe.
- R8: While streaming, each write advances the line by one. Line 15 wraps to line 0 and moves the segment up by one.
- R9: While streaming, once the segment has moved past 7, each further byte gives an error pulse and causes no write.
- R10: A start strobe puts the decoder into waiting for a segment. A stop strobe puts it into idle and ends streaming. If both strobes come in the same cycle, the start strobe wins. A byte that arrives in the same cycle as either strobe is ignored. A byte received while idle gives an error pulse.
- R11: A byte in a position where it is not allowed gives a one-cycle error pulse and no write. The decoder's position in the sequence does not change.
- R12: The write strobe, address, data and error outputs are registered. Each one appears in the cycle after the byte's clock edge. The write strobe is high for exactly one cycle per accepted data byte, and it is never high in the same cycle as the error pulse. After reset, all outputs are 0 and the decoder is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transaction start strobe |
| stop_i | input | 1 | Transaction stop strobe |
| byte_vld_i | input | 1 | Byte valid this cycle |
| byte_i | input | 8 | Received byte |
| wr_en_o | output | 1 | Font RAM write strobe |
| wr_addr_o | output | 7 | Font RAM write address {segment, line} |
| wr_data_o | output | 5 | Font RAM write data (pixel row) |
| err_o | output | 1 | Sequence or range error pulse |

## Verification
A wrong sequencing state shows up at the ports at the next byte:
- If the decoder is in the wrong state, the next byte either writes when it should give an error, or gives an error when it should write. Both cases are visible one cycle after that byte.
- A wrong address counter stays hidden until the next streaming write. It then appears as a wrong `wr_addr_o`. The wrap from line 15 and the stop after segment 7 are the places where such faults are forced to show.

The bench runs a reference model cycle by cycle and compares all four outputs on every clock. A wrong state is therefore reported in the first cycle where its effect reaches the outputs.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

  typedef enum logic [1:0] {
    TAG_LINE = 2'b00,
    TAG_LSTR = 2'b01,
    TAG_RSVD = 2'b10,
    TAG_SEG  = 2'b11
  } tag_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEG,
    ST_LINE,
    ST_INFO,
    ST_NEXT,
    ST_STREAM
  } st_e;

  function automatic tag_e tag_of(input logic [1:0] top);
    return tag_e'(top);
  endfunction

endpackage

// File: rtl/fsd_classify.sv
module fsd_classify
  import fsd_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SEG_W  = 4,
  parameter int LINE_W = 4,
  parameter int DATA_W = 5
) (
  input  logic [BYTE_W-1:0] byte_i,
  output tag_e              tag_o,
  output logic [SEG_W-1:0]  seg_val_o,
  output logic [LINE_W-1:0] line_val_o,
  output logic [DATA_W-1:0] pix_o
);

  logic ign_unused;

  assign tag_o      = tag_of(byte_i[BYTE_W-1 -: 2]);
  assign seg_val_o  = byte_i[SEG_W-1:0];
  assign line_val_o = byte_i[LINE_W-1:0];
  assign pix_o      = byte_i[DATA_W-1:0];
  assign ign_unused = ^byte_i;

endmodule

// File: rtl/fsd_addr.sv
module fsd_addr #(
  parameter int SEG_W      = 4,
  parameter int LINE_W     = 4,
  parameter int USER_CODES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_seg_i,
  input  logic              ld_line_i,
  input  logic              adv_i,
  input  logic [SEG_W-1:0]  seg_val_i,
  input  logic [LINE_W-1:0] line_val_i,
  output logic [SEG_W-1:0]  seg_o,
  output logic [LINE_W-1:0] line_o,
  output logic              new_ok_o,
  output logic              cur_ok_o
);

  localparam logic [LINE_W-1:0] LINE_LAST = '1;

  function automatic logic code_ok(input logic [SEG_W-1:0] s);
    return 32'(s) < USER_CODES;
  endfunction

  function automatic logic [LINE_W-1:0] line_step(input logic [LINE_W-1:0] l);
    return (l == LINE_LAST) ? '0 : l + 1'b1;
  endfunction

  function automatic logic [SEG_W-1:0] seg_step(input logic [SEG_W-1:0] s,
                                                input logic [LINE_W-1:0] l);
    return (l == LINE_LAST) ? s + 1'b1 : s;
  endfunction

  logic [SEG_W-1:0]  seg_q;
  logic [LINE_W-1:0] line_q;
  logic              wrap_evt;

  assign wrap_evt = adv_i && (line_q == LINE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= '0;
      line_q <= '0;
    end else begin
      if (ld_seg_i)       seg_q <= seg_val_i;
      else if (adv_i)     seg_q <= seg_step(seg_q, line_q);
      if (ld_line_i)      line_q <= line_val_i;
      else if (adv_i)     line_q <= line_step(line_q);
    end
  end

  assign seg_o    = seg_q;
  assign line_o   = line_q;
  assign new_ok_o = code_ok(seg_val_i);
  assign cur_ok_o = code_ok(seg_q);

  // R8
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt && !ld_seg_i && !ld_line_i |=> (line_q == '0) && (seg_q == $past(seg_q) + 1'b1));

  // R9
  adv_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |-> code_ok(seg_q));

endmodule

// File: rtl/fsd_ctrl.sv
module fsd_ctrl
  import fsd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic vld_i,
  input  tag_e tag_i,
  input  logic new_ok_i,
  input  logic cur_ok_i,
  output logic ld_seg_o,
  output logic ld_line_o,
  output logic wr_o,
  output logic adv_o,
  output logic err_o
);

  st_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    ld_seg_o  = 1'b0;
    ld_line_o = 1'b0;
    wr_o      = 1'b0;
    adv_o     = 1'b0;
    err_o     = 1'b0;
    if (start_i) begin
      st_d = ST_SEG;
    end else if (stop_i) begin
      st_d = ST_IDLE;
    end else if (vld_i) begin
      unique case (st_q)
        ST_IDLE: err_o = 1'b1;
        ST_SEG: begin
          if (tag_i == TAG_SEG && new_ok_i) begin
            ld_seg_o = 1'b1;
            st_d     = ST_LINE;
          end else err_o = 1'b1;
        end
        ST_LINE: begin
          if (tag_i == TAG_LINE) begin
            ld_line_o = 1'b1;
            st_d      = ST_INFO;
          end else if (tag_i == TAG_LSTR) begin
            ld_line_o = 1'b1;
            st_d      = ST_STREAM;
          end else err_o = 1'b1;
        end
        ST_INFO: begin
          wr_o = 1'b1;
          st_d = ST_NEXT;
        end
        ST_NEXT: begin
          if (tag_i == TAG_SEG && new_ok_i) begin
            ld_seg_o = 1'b1;
            st_d     = ST_LINE;
          end else if (tag_i == TAG_LINE) begin
            ld_line_o = 1'b1;
            st_d      = ST_INFO;
          end else err_o = 1'b1;
        end
        ST_STREAM: begin
          if (cur_ok_i) begin
            wr_o  = 1'b1;
            adv_o = 1'b1;
          end else err_o = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // R7
  stream_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STREAM) && !start_i && !stop_i |=> st_q == ST_STREAM);

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && !start_i |=> st_q == ST_IDLE);

  // R11
  err_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> $stable(st_q));

  // R12
  wr_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_o && err_o));

endmodule

// File: rtl/font_stream_dec.sv
module font_stream_dec
  import fsd_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int SEG_W      = 4,
  parameter int LINE_W     = 4,
  parameter int DATA_W     = 5,
  parameter int USER_CODES = 8,
  localparam int CODE_W    = $clog2(USER_CODES),
  localparam int ADDR_W    = CODE_W + LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              err_o
);

  tag_e              tag;
  logic [SEG_W-1:0]  seg_val, seg_cur;
  logic [LINE_W-1:0] line_val, line_cur;
  logic [DATA_W-1:0] pix;
  logic              ld_seg, ld_line, do_wr, do_adv, seq_err, new_ok, cur_ok;

  fsd_classify #(.BYTE_W(BYTE_W), .SEG_W(SEG_W), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_cls (
    .byte_i(byte_i), .tag_o(tag), .seg_val_o(seg_val), .line_val_o(line_val), .pix_o(pix)
  );

  fsd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .vld_i(byte_vld_i),
    .tag_i(tag), .new_ok_i(new_ok), .cur_ok_i(cur_ok), .ld_seg_o(ld_seg),
    .ld_line_o(ld_line), .wr_o(do_wr), .adv_o(do_adv), .err_o(seq_err)
  );

  fsd_addr #(.SEG_W(SEG_W), .LINE_W(LINE_W), .USER_CODES(USER_CODES)) u_addr (
    .clk(clk), .rst_n(rst_n), .ld_seg_i(ld_seg), .ld_line_i(ld_line), .adv_i(do_adv),
    .seg_val_i(seg_val), .line_val_i(line_val), .seg_o(seg_cur), .line_o(line_cur),
    .new_ok_o(new_ok), .cur_ok_o(cur_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o   <= 1'b0;
      err_o     <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= do_wr;
      err_o   <= seq_err;
      if (do_wr) begin
        wr_addr_o <= {seg_cur[CODE_W-1:0], line_cur};
        wr_data_o <= pix;
      end
    end
  end

  // R12
  wr_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(byte_vld_i));

  // R12
  out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_o && err_o));

endmodule

// File: tb/tb_font_stream_dec.sv
module tb_font_stream_dec;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic       wr_en_o, err_o;
  logic [6:0] wr_addr_o;
  logic [4:0] wr_data_o;

  font_stream_dec dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  string req = "R12";
  bit done = 0;

  // reference model: 0 idle 1 wait seg 2 wait line 3 wait data 4 after data 5 streaming
  int ms = 0, mseg = 0, mline = 0;
  logic e_wr = 0, e_err = 0;
  int e_addr = 0, e_data = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      automatic int tg = byte_i[7:6];
      automatic int v = byte_i[3:0];
      e_wr  <= 0;
      e_err <= 0;
      if (start_i) ms = 1;
      else if (stop_i) ms = 0;
      else if (byte_vld_i) begin
        if (ms == 0) e_err <= 1;
        else if (ms == 1) begin
          if (tg == 3 && v < 8) begin mseg = v; ms = 2; end
          else e_err <= 1;
        end else if (ms == 2) begin
          if (tg == 0) begin mline = v; ms = 3; end
          else if (tg == 1) begin mline = v; ms = 5; end
          else e_err <= 1;
        end else if (ms == 3) begin
          e_wr <= 1; e_addr <= mseg * 16 + mline; e_data <= byte_i & 8'h1F; ms = 4;
        end else if (ms == 4) begin
          if (tg == 3 && v < 8) begin mseg = v; ms = 2; end
          else if (tg == 0) begin mline = v; ms = 3; end
          else e_err <= 1;
        end else begin
          if (mseg < 8) begin
            e_wr <= 1; e_addr <= mseg * 16 + mline; e_data <= byte_i & 8'h1F;
            mline = mline + 1;
            if (mline == 16) begin mline = 0; mseg = mseg + 1; end
          end else e_err <= 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (wr_en_o !== e_wr || err_o !== e_err ||
          int'(wr_addr_o) != e_addr || int'(wr_data_o) != e_data) begin
        bad++;
        $display("FAIL %s: got wr=%b err=%b addr=%0h data=%0h exp wr=%b err=%b addr=%0h data=%0h",
                 req, wr_en_o, err_o, wr_addr_o, wr_data_o, e_wr, e_err, e_addr, e_data);
      end
    end
  end

  task automatic step(input bit v, input logic [7:0] b, input bit st, input bit sp);
    start_i = st; stop_i = sp; byte_vld_i = v; byte_i = b;
    @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b);
    step(1, b, 0, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      bad++;
      $display("FAIL watchdog: got running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    req = "R12";
    total++;
    if (wr_en_o !== 0 || err_o !== 0 || wr_addr_o !== 0 || wr_data_o !== 0) begin
      bad++;
      $display("FAIL R12 reset: got %b%b %0h %0h expected 0 0 0 0", wr_en_o, err_o, wr_addr_o, wr_data_o);
    end
    rst_n = 1;
    @(negedge clk);

    req = "R10"; put(8'hC1); put(8'h02);
    step(0, 0, 1, 0);
    req = "R1";  put(8'hF2);
    req = "R2";  put(8'h05);
    req = "R4";  put(8'hFF);
    req = "R5";  put(8'hC7); put(8'h0F); put(8'hE3);
    req = "R6";  put(8'h03); put(8'h11); put(8'h04); put(8'h0A);
    req = "R11"; put(8'h80); put(8'h0C); put(8'h16);
    req = "R3";  put(8'h49); put(8'h06); put(8'h41); put(8'h15);
    req = "R1";  put(8'hC0); put(8'hE0); put(8'h01); put(8'h1E);
    step(0, 0, 0, 0);

    step(0, 0, 1, 0);
    req = "R1";  put(8'hC9); put(8'hCF);
    req = "R11"; put(8'h05); put(8'h85);
    req = "R3";  put(8'hC6); put(8'h4E);
    req = "R7";  put(8'hC1); put(8'h82); put(8'h43);
    req = "R8";
    for (int i = 0; i < 15; i++) put(8'(i * 7));
    req = "R9";  put(8'h1F); put(8'h00); put(8'hC3);
    req = "R10"; step(1, 8'h00, 0, 1); put(8'h00);

    step(1, 8'hC2, 1, 0);
    req = "R3"; put(8'hC2); put(8'h40); put(8'h0A); put(8'h0B);
    req = "R10"; step(0, 0, 1, 1);
    put(8'hC3); put(8'h07); put(8'h1C);
    step(0, 0, 0, 1);
    put(8'hC3);
    step(1, 8'hC4, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
    finish_run();
  end

endmodule